// File: doc/BRIEF.md
# Video and Sliced-Text Output Bus Arbiter

This block lets two sources share a single output byte bus: a stream of scaled video bytes and a stream of sliced text (data captured during the blanking interval). Video is the normal owner of the bus. A text line is only ever sent between two video lines. It must be fully buffered upstream, and it starts only once the video line in progress has ended and the video FIFO holds nothing that is waiting to go out. Once a text line has started, it is sent to its end without a break. Video bytes that arrive during that time wait in their FIFO.

Every byte placed on the bus is marked by a one-cycle data-qualifier strobe. A framing flag marks the span of sliced data. It rises together with the first header byte of a text burst. It falls together with the next video byte tagged as a start-of-active-video code. Because of this, the flag can stay high over several text lines, and over untagged video bytes, until that code is seen.

The block pops one byte per cycle from whichever source it grants. The byte, the strobe and the flag are all registered and appear on the cycle after the pop.

Top module: `vt_bus_arbiter`

## Requirements
- R1: In the cycle after a clock edge with reset low, out_dq and out_flag are 0, out_data is all zeros, and neither pop is asserted while reset is low.
- R2: A video byte that is available is popped when no text line is in progress. That byte appears on out_data with out_dq high on the next cycle.
- R3: At a line boundary, meaning after reset or after a byte tagged with vid_eol, video has priority. If vid_avail is high there, the video byte is popped even when a text line is ready.
- R4: A text line may start only at a line boundary while vid_avail is low. While a video line is still open (its vid_eol byte not yet popped), no text is popped, even if the video FIFO is empty.
- R5: Once the first byte of a text line has been popped, text bytes are popped on every cycle that txt_rdy is high, up to and including the byte tagged txt_last. No video byte is popped during this time.
- R6: out_flag goes from 0 to 1 on the same cycle that the first header byte of a text burst appears on the bus with out_dq high.
- R7: out_flag returns to 0 on the same cycle that a video byte popped with vid_sav high appears on the bus. Until then it stays high, across further text lines and across video bytes without vid_sav.
- R8: In a cycle where nothing is popped, out_dq is 0 on the next cycle and out_data keeps its previous value.
- R9: vid_pop and txt_pop are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_avail | input | 1 | Video FIFO holds at least one byte |
| vid_byte | input | DATA_W | Byte at the head of the video FIFO |
| vid_eol | input | 1 | Head video byte is the last byte of its line |
| vid_sav | input | 1 | Head video byte is a start-of-active-video code |
| vid_pop | output | 1 | Consume the head video byte this cycle |
| txt_rdy | input | 1 | Text buffer holds a complete line (and its remaining bytes) |
| txt_byte | input | DATA_W | Byte at the head of the text buffer |
| txt_last | input | 1 | Head text byte is the last of its line |
| txt_pop | output | 1 | Consume the head text byte this cycle |
| out_data | output | DATA_W | Shared output bus |
| out_dq | output | 1 | Data qualifier: out_data carries a new byte |
| out_flag | output | 1 | Sliced-data framing flag |

## Verification
Several input patterns are used. A text line offered with the bus idle shows whether text can start from a boundary. A video line that stalls midway with its FIFO empty, while text is ready, tells an end-of-line condition apart from a mere empty FIFO. Video that arrives partway through a text line shows whether text runs to completion. Video and text offered at the same boundary expose a wrong priority. Two text lines back to back, followed by a video line with no start-of-active-video tag, show whether the flag correctly stays high until a tagged byte is sent.

// File: rtl/vt_arb_pkg.sv
// Shared types for the video/text output bus arbiter.
package vt_arb_pkg;
    // Arbiter position: between lines, inside a video line, inside a text line.
    typedef enum logic [1:0] {
        ST_GAP = 2'd0,
        ST_VID = 2'd1,
        ST_TXT = 2'd2
    } arb_state_t;
endpackage

// File: rtl/vt_arb_fsm.sv
// Grant state machine. Decides each cycle which source is popped.
// Assumes: once txt_rdy is high for a line, it stays high until the
// txt_last byte is popped (the line is fully buffered upstream).
module vt_arb_fsm
    import vt_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_avail,
    input  logic vid_eol,
    input  logic txt_rdy,
    input  logic txt_last,
    output logic vid_pop,
    output logic txt_pop
);
    arb_state_t st, st_nxt;

    // Grant decision and next state from the current position and the inputs.
    always_comb begin
        vid_pop = 1'b0;
        txt_pop = 1'b0;
        st_nxt  = st;
        case (st)
            ST_GAP: begin
                if (vid_avail) begin
                    vid_pop = 1'b1;
                    st_nxt  = vid_eol ? ST_GAP : ST_VID;
                end else if (txt_rdy) begin
                    txt_pop = 1'b1;
                    st_nxt  = txt_last ? ST_GAP : ST_TXT;
                end
            end
            ST_VID: begin
                if (vid_avail) begin
                    vid_pop = 1'b1;
                    st_nxt  = vid_eol ? ST_GAP : ST_VID;
                end
            end
            ST_TXT: begin
                if (txt_rdy) begin
                    txt_pop = 1'b1;
                    st_nxt  = txt_last ? ST_GAP : ST_TXT;
                end
            end
            default: st_nxt = ST_GAP;
        endcase
        if (!rst_n) begin
            vid_pop = 1'b0;
            txt_pop = 1'b0;
            st_nxt  = ST_GAP;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        st <= st_nxt;
    end

    // R9
    pop_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_pop, txt_pop}));

    // R5
    text_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txt_pop && !txt_last) |=> !vid_pop);

    // R4
    open_line_no_text_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_pop && !vid_eol) |=> !txt_pop);
endmodule

// File: rtl/vt_out_stage.sv
// Output register. Presents the granted byte with a one-cycle qualifier.
// Assumes at most one pop per cycle. Holds the bus value while idle.
module vt_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_pop,
    input  logic              txt_pop,
    input  logic [DATA_W-1:0] vid_byte,
    input  logic [DATA_W-1:0] txt_byte,
    output logic [DATA_W-1:0] out_data,
    output logic              out_dq
);
    // Register the granted byte and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_dq   <= 1'b0;
        end else begin
            out_dq <= vid_pop | txt_pop;
            if (vid_pop)      out_data <= vid_byte;
            else if (txt_pop) out_data <= txt_byte;
        end
    end

    // R2
    video_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_pop |=> (out_dq && out_data == $past(vid_byte)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_pop && !txt_pop) |=> (!out_dq && $stable(out_data)));
endmodule

// File: rtl/vt_flag_ctl.sv
// Framing flag for sliced data. Set when a text byte goes out, cleared
// when a video byte tagged as start-of-active-video goes out.
module vt_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic txt_pop,
    input  logic vid_pop,
    input  logic vid_sav,
    output logic out_flag
);
    // Update the flag in step with the byte that goes onto the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_flag <= 1'b0;
        else if (txt_pop)            out_flag <= 1'b1;
        else if (vid_pop && vid_sav) out_flag <= 1'b0;
    end

    // R6
    flag_with_text_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txt_pop |=> out_flag);

    // R7
    flag_drop_sav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_pop && vid_sav) |=> !out_flag);

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_flag && !(vid_pop && vid_sav)) |=> out_flag);
endmodule

// File: rtl/vt_bus_arbiter.sv
// Top level: shares one output byte bus between video and sliced text.
// Text lines are inserted only between video lines while the video FIFO
// is empty. Outputs are registered one cycle after the pop.
module vt_bus_arbiter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_avail,
    input  logic [DATA_W-1:0] vid_byte,
    input  logic              vid_eol,
    input  logic              vid_sav,
    output logic              vid_pop,
    input  logic              txt_rdy,
    input  logic [DATA_W-1:0] txt_byte,
    input  logic              txt_last,
    output logic              txt_pop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_dq,
    output logic              out_flag
);
    vt_arb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_avail (vid_avail),
        .vid_eol   (vid_eol),
        .txt_rdy   (txt_rdy),
        .txt_last  (txt_last),
        .vid_pop   (vid_pop),
        .txt_pop   (txt_pop)
    );

    vt_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_pop  (vid_pop),
        .txt_pop  (txt_pop),
        .vid_byte (vid_byte),
        .txt_byte (txt_byte),
        .out_data (out_data),
        .out_dq   (out_dq)
    );

    vt_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .txt_pop  (txt_pop),
        .vid_pop  (vid_pop),
        .vid_sav  (vid_sav),
        .out_flag (out_flag)
    );

    // R3
    video_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_pop && vid_eol && vid_avail) |=> !(txt_pop && vid_avail));
endmodule

// File: tb/tb_vt_bus_arbiter.sv
// Bench: behavioural reference model with queues, compared on every cycle.
module tb_vt_bus_arbiter;
    localparam int CLK_PERIOD = 10;

    typedef struct packed { logic [7:0] d; logic eol; logic sav; } vitem_t;
    typedef struct packed { logic [7:0] d; logic last; } titem_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_avail = 1'b0, vid_eol = 1'b0, vid_sav = 1'b0;
    logic [7:0] vid_byte = '0, txt_byte = '0;
    logic       txt_rdy = 1'b0, txt_last = 1'b0;
    logic       vid_pop, txt_pop, out_dq, out_flag;
    logic [7:0] out_data;

    vt_bus_arbiter #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .vid_avail(vid_avail), .vid_byte(vid_byte), .vid_eol(vid_eol),
        .vid_sav(vid_sav), .vid_pop(vid_pop),
        .txt_rdy(txt_rdy), .txt_byte(txt_byte), .txt_last(txt_last),
        .txt_pop(txt_pop),
        .out_data(out_data), .out_dq(out_dq), .out_flag(out_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    vitem_t vq[$];
    titem_t tq[$];
    int errors = 0, checks = 0;
    bit done = 1'b0;

    // model state: 0 between lines, 1 in video line, 2 in text line
    int     m_pos = 0;
    bit     have_exp = 1'b0, exp_rst = 1'b0;
    logic [7:0] e_data = '0;
    bit     e_dq = 1'b0, e_flag = 1'b0, e_flag_prev = 1'b0;
    logic [7:0] vseed = 8'h10, tseed = 8'hA0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic push_vid(input int n, input bit with_sav, input bit with_eol);
        for (int i = 0; i < n; i++) begin
            vitem_t it;
            it.sav = with_sav && (i == 0);
            it.d   = it.sav ? 8'h80 : vseed;
            it.eol = with_eol && (i == n - 1);
            vseed++;
            vq.push_back(it);
        end
    endtask

    task automatic push_txt(input int n);
        for (int i = 0; i < n; i++) begin
            titem_t it;
            it.d    = (i == 0) ? 8'h00 : tseed;
            it.last = (i == n - 1);
            tseed++;
            tq.push_back(it);
        end
    endtask

    task automatic step();
        bit gv, gt;
        @(negedge clk);
        if (have_exp) begin
            string tg_d, tg_f;
            if (exp_rst)      tg_d = "R1";
            else if (!e_dq)   tg_d = "R8";
            else              tg_d = "R2";
            if (exp_rst)                     tg_f = "R1";
            else if (e_flag && !e_flag_prev) tg_f = "R6";
            else                             tg_f = "R7";
            chk(out_dq === e_dq, tg_d, "out_dq", int'(out_dq), int'(e_dq));
            chk(out_data === e_data, tg_d, "out_data", int'(out_data), int'(e_data));
            chk(out_flag === e_flag, tg_f, "out_flag", int'(out_flag), int'(e_flag));
        end
        vid_avail = (vq.size() > 0);
        vid_byte  = vid_avail ? vq[0].d : 8'h00;
        vid_eol   = vid_avail ? vq[0].eol : 1'b0;
        vid_sav   = vid_avail ? vq[0].sav : 1'b0;
        txt_rdy   = (tq.size() > 0);
        txt_byte  = txt_rdy ? tq[0].d : 8'h00;
        txt_last  = txt_rdy ? tq[0].last : 1'b0;
        #1;
        gv = 1'b0; gt = 1'b0;
        if (rst_n) begin
            if (m_pos == 2) gt = txt_rdy;
            else if (vid_avail) gv = 1'b1;
            else if (m_pos == 0) gt = txt_rdy;
        end
        chk(!(vid_pop && txt_pop), "R9", "both pops", int'({vid_pop, txt_pop}), 0);
        chk(vid_pop === gv, rst_n ? "R3" : "R1", "vid_pop", int'(vid_pop), int'(gv));
        chk(txt_pop === gt, !rst_n ? "R1" : (m_pos == 2 ? "R5" : "R4"),
            "txt_pop", int'(txt_pop), int'(gt));
        e_flag_prev = e_flag;
        exp_rst = !rst_n;
        have_exp = 1'b1;
        if (!rst_n) begin
            m_pos = 0; e_data = '0; e_dq = 1'b0; e_flag = 1'b0;
        end else if (gv) begin
            vitem_t it = vq.pop_front();
            e_data = it.d; e_dq = 1'b1;
            if (it.sav) e_flag = 1'b0;
            m_pos = it.eol ? 0 : 1;
        end else if (gt) begin
            titem_t it = tq.pop_front();
            e_data = it.d; e_dq = 1'b1; e_flag = 1'b1;
            m_pos = it.last ? 0 : 2;
        end else begin
            e_dq = 1'b0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(3);                          // R1 then R8 idle
        push_txt(4);  run(8);            // text from idle boundary: R4, R6
        push_vid(6, 1'b1, 1'b1); run(10);// SAV clears flag: R7, R2
        push_vid(3, 1'b1, 1'b0);         // open line, stalls empty
        push_txt(3);  run(8);            // R4: text must wait
        push_vid(3, 1'b0, 1'b1); run(12);// line closes, then text
        push_txt(6);  run(2);
        push_vid(4, 1'b1, 1'b1); run(16);// R5: text completes first
        push_vid(4, 1'b1, 1'b1);
        push_txt(3);  run(14);           // R3: video first at boundary
        push_txt(3); push_txt(2); run(10);// two text lines, flag held
        push_vid(3, 1'b0, 1'b1); run(6); // R7: no SAV, flag stays
        push_vid(3, 1'b1, 1'b1); run(6); // SAV drops flag
        run(3);                          // R8 idle hold
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule